// File: doc/BRIEF.md
# Half-Duplex Backpressure Jam Generator

This block applies flow control to a half-duplex Ethernet link by forcing collisions. It is enabled by a transmit flow-control bit and a half-duplex mode bit. Backpressure can then be requested in three ways: by a software bit, by a sideband input, or (when hardware flow control is on) by the receive queue fill level rising above an activate threshold. When backpressure is requested and the local receiver sees an incoming frame begin, the block drives a fixed 32-byte jam onto the transmit byte stream. The remote station sees a collision and backs off.

The same byte stream carries ordinary application frames through a valid/ready handshake. Backpressure never blocks them. A jam is issued once per rising edge of receive activity. It never cuts into a frame that is already being sent. If the line is busy with local data when reception starts, that jam is dropped rather than deferred.

Top module: `hdbp_jam_gen`

## Requirements
- R1: After reset, `tx_valid_o` is low and `app_ready_o` is high while `app_valid_i` is low.
- R2: When backpressure is requested and `rx_active_i` rises while the transmitter is idle, exactly 32 consecutive valid bytes of value 0x55 are driven, the first one in the cycle after the edge is sampled.
- R3: With `txfc_en_i` low no jam is ever driven, whatever the request, mode and threshold inputs are.
- R4: With `half_duplex_i` low (full duplex) no jam is ever driven.
- R5: With `txfc_en_i` and `half_duplex_i` high, either `sw_req_i` or `sb_req_i` alone requests backpressure.
- R6: With `hwfc_en_i` high, a `rxq_level_i` strictly greater than `rxq_thr_i` requests backpressure; a level equal to the threshold does not, and with `hwfc_en_i` low the level has no effect.
- R7: One jam is issued per rising edge of `rx_active_i`; holding it high issues no further jam, and a fresh rising edge issues a new one.
- R8: A rising edge of `rx_active_i` during an application frame in progress produces no jam, neither during nor after that frame.
- R9: Application frames are sent while backpressure is active: each accepted byte (`app_valid_i` and `app_ready_o` high at a clock edge) appears on `tx_data_o` with `tx_valid_o` in the next cycle, in order.
- R10: When a jam trigger and a pending application byte coincide on an idle line, the jam wins: `app_ready_o` is low in that cycle and the frame follows the jam.
- R11: `app_ready_o` stays low for the whole jam.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| txfc_en_i | input | 1 | Transmit flow-control enable |
| hwfc_en_i | input | 1 | Queue-threshold flow-control enable |
| half_duplex_i | input | 1 | 1 = half duplex, 0 = full duplex |
| sw_req_i | input | 1 | Software backpressure request |
| sb_req_i | input | 1 | Sideband backpressure request |
| rxq_level_i | input | LVL_W | Receive queue fill level |
| rxq_thr_i | input | LVL_W | Receive queue activate threshold |
| rx_active_i | input | 1 | Carrier / receive-active indication |
| app_valid_i | input | 1 | Application byte valid |
| app_data_i | input | DATA_W | Application byte |
| app_last_i | input | 1 | Last byte of application frame |
| app_ready_o | output | 1 | Application byte accepted this cycle |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_data_o | output | DATA_W | Transmit byte |

## Verification
The assertions take several things for granted about the inputs. `rx_active_i` is already synchronous to `clk_i`. An application source keeps `app_valid_i` and its data stable until they are accepted. The configuration bits do not change while a jam is in flight. The stimulus follows these rules by changing every input 2 ns after a rising edge. It also holds configuration fixed across each scenario and keeps `app_valid_i` high from the first byte of a frame to the last, so that frames are back-to-back.

// File: rtl/hdbp_pkg.sv
package hdbp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_JAM  = 2'd1,
    ST_APP  = 2'd2
  } tx_state_e;
endpackage

// File: rtl/hdbp_req_gen.sv
module hdbp_req_gen #(
  parameter int unsigned LVL_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             txfc_en_i,
  input  logic             hwfc_en_i,
  input  logic             half_duplex_i,
  input  logic             sw_req_i,
  input  logic             sb_req_i,
  input  logic [LVL_W-1:0] rxq_level_i,
  input  logic [LVL_W-1:0] rxq_thr_i,
  output logic             bp_o
);
  logic thr_hit;
  logic any_req;

  assign thr_hit = hwfc_en_i && (rxq_level_i > rxq_thr_i);
  assign any_req = sw_req_i || sb_req_i || thr_hit;
  assign bp_o    = txfc_en_i && half_duplex_i && any_req;

  // R3
  txfc_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !txfc_en_i |-> !bp_o);
  // R4
  full_dup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !half_duplex_i |-> !bp_o);
endmodule

// File: rtl/hdbp_rx_edge.sv
module hdbp_rx_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_active_i,
  output logic rise_o
);
  logic rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_q <= 1'b0;
    else         rx_q <= rx_active_i;
  end

  assign rise_o = rx_active_i && !rx_q;
endmodule

// File: rtl/hdbp_tx_arb.sv
module hdbp_tx_arb
  import hdbp_pkg::*;
#(
  parameter int unsigned         DATA_W   = 8,
  parameter int unsigned         JAM_LEN  = 32,
  parameter logic [DATA_W-1:0]   JAM_BYTE = 8'h55
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bp_i,
  input  logic              rx_rise_i,
  input  logic              app_valid_i,
  input  logic [DATA_W-1:0] app_data_i,
  input  logic              app_last_i,
  output logic              app_ready_o,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_data_o
);
  localparam int unsigned CNT_W = $clog2(JAM_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(JAM_LEN);

  tx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              jam_go;
  logic              app_fire;

  // jam only from idle: a busy line skips the trigger
  assign jam_go      = (state_q == ST_IDLE) && bp_i && rx_rise_i;
  assign app_ready_o = (state_q == ST_APP) || ((state_q == ST_IDLE) && !jam_go);
  assign app_fire    = app_valid_i && app_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      tx_valid_o <= 1'b0;
      tx_data_o  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (jam_go) begin
            state_q    <= ST_JAM;
            cnt_q      <= CNT_W'(1);
            tx_valid_o <= 1'b1;
            tx_data_o  <= JAM_BYTE;
          end else if (app_fire) begin
            state_q    <= app_last_i ? ST_IDLE : ST_APP;
            tx_valid_o <= 1'b1;
            tx_data_o  <= app_data_i;
          end else begin
            tx_valid_o <= 1'b0;
          end
        end
        ST_JAM: begin
          if (cnt_q == CNT_END) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            tx_valid_o <= 1'b0;
          end else begin
            cnt_q      <= cnt_q + CNT_W'(1);
            tx_valid_o <= 1'b1;
            tx_data_o  <= JAM_BYTE;
          end
        end
        ST_APP: begin
          if (app_fire) begin
            if (app_last_i) state_q <= ST_IDLE;
            tx_valid_o <= 1'b1;
            tx_data_o  <= app_data_i;
          end else begin
            tx_valid_o <= 1'b0;
          end
        end
        default: begin
          state_q    <= ST_IDLE;
          tx_valid_o <= 1'b0;
        end
      endcase
    end
  end

  // checker: length of each jam burst
  logic [CNT_W:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                run_q <= '0;
    else if (state_q == ST_JAM) run_q <= run_q + 1'b1;
    else                        run_q <= '0;
  end

  // R2
  jam_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_JAM && run_q != 0) |-> run_q == (CNT_W+1)'(JAM_LEN));
  // R2
  jam_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_JAM) |-> (tx_valid_o && tx_data_o == JAM_BYTE));
  // R2
  jam_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && bp_i && rx_rise_i) |=> state_q == ST_JAM);
  // R8
  no_preempt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_APP) |=> state_q != ST_JAM);
  // R9
  app_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (app_valid_i && app_ready_o) |=> (tx_valid_o && tx_data_o == $past(app_data_i)));
  // R11
  ready_jam_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_JAM) |-> !app_ready_o);
endmodule

// File: rtl/hdbp_jam_gen.sv
module hdbp_jam_gen #(
  parameter int unsigned       LVL_W    = 13,
  parameter int unsigned       DATA_W   = 8,
  parameter int unsigned       JAM_LEN  = 32,
  parameter logic [DATA_W-1:0] JAM_BYTE = 8'h55
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              txfc_en_i,
  input  logic              hwfc_en_i,
  input  logic              half_duplex_i,
  input  logic              sw_req_i,
  input  logic              sb_req_i,
  input  logic [LVL_W-1:0]  rxq_level_i,
  input  logic [LVL_W-1:0]  rxq_thr_i,
  input  logic              rx_active_i,
  input  logic              app_valid_i,
  input  logic [DATA_W-1:0] app_data_i,
  input  logic              app_last_i,
  output logic              app_ready_o,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_data_o
);
  logic bp;
  logic rx_rise;

  hdbp_req_gen #(.LVL_W(LVL_W)) i_req (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .txfc_en_i    (txfc_en_i),
    .hwfc_en_i    (hwfc_en_i),
    .half_duplex_i(half_duplex_i),
    .sw_req_i     (sw_req_i),
    .sb_req_i     (sb_req_i),
    .rxq_level_i  (rxq_level_i),
    .rxq_thr_i    (rxq_thr_i),
    .bp_o         (bp)
  );

  hdbp_rx_edge i_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_active_i(rx_active_i),
    .rise_o     (rx_rise)
  );

  hdbp_tx_arb #(
    .DATA_W  (DATA_W),
    .JAM_LEN (JAM_LEN),
    .JAM_BYTE(JAM_BYTE)
  ) i_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bp_i       (bp),
    .rx_rise_i  (rx_rise),
    .app_valid_i(app_valid_i),
    .app_data_i (app_data_i),
    .app_last_i (app_last_i),
    .app_ready_o(app_ready_o),
    .tx_valid_o (tx_valid_o),
    .tx_data_o  (tx_data_o)
  );
endmodule

// File: tb/test_hdbp_jam_gen.sv
`timescale 1ns/1ps
module test_hdbp_jam_gen;
  localparam int LVL_W = 13;
  localparam int JLEN  = 32;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic txfc_en_i = 0, hwfc_en_i = 0, half_duplex_i = 0, sw_req_i = 0, sb_req_i = 0;
  logic [LVL_W-1:0] rxq_level_i = '0, rxq_thr_i = '0;
  logic rx_active_i = 0, app_valid_i = 0, app_last_i = 0;
  logic [7:0] app_data_i = '0;
  logic app_ready_o, tx_valid_o;
  logic [7:0] tx_data_o;

  always #10 clk_i = ~clk_i;

  hdbp_jam_gen i_hdbp_jam_gen (
    .clk_i, .rst_ni, .txfc_en_i, .hwfc_en_i, .half_duplex_i, .sw_req_i, .sb_req_i,
    .rxq_level_i, .rxq_thr_i, .rx_active_i, .app_valid_i, .app_data_i, .app_last_i,
    .app_ready_o, .tx_valid_o, .tx_data_o
  );

  int checks = 0, fails = 0;
  int vcount = 0, run = 0, last_run = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  string      cur_tag = "R1";

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (tx_valid_o) begin
        vcount++;
        run++;
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL %s: unexpected byte actual 0x%02h expected none", cur_tag, tx_data_o);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(tx_data_o == e, t, int'(tx_data_o), int'(e));
        end
      end else begin
        if (run != 0) last_run = run;
        run = 0;
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk_i);
    #2;
  endtask

  task automatic push_jam(string tag);
    for (int i = 0; i < JLEN; i++) begin
      exp_q.push_back(8'h55);
      tag_q.push_back(tag);
    end
  endtask

  task automatic cfg(bit txfc, bit hwfc, bit hd, bit sw, bit sb, int lvl, int thr);
    step(1);
    txfc_en_i = txfc; hwfc_en_i = hwfc; half_duplex_i = hd;
    sw_req_i = sw; sb_req_i = sb;
    rxq_level_i = LVL_W'(lvl); rxq_thr_i = LVL_W'(thr);
  endtask

  task automatic rx_pulse(int hold);
    step(1);
    rx_active_i = 1'b1;
    step(hold);
    rx_active_i = 1'b0;
    step(3);
  endtask

  task automatic drain(string tag);
    step(45);
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  task automatic send_frame(int n, int base, string tag);
    for (int i = 0; i < n; i++) begin
      app_valid_i = 1'b1;
      app_data_i  = 8'(base + i);
      app_last_i  = (i == n - 1);
      forever begin
        @(negedge clk_i);
        if (app_ready_o) break;
        @(posedge clk_i); #2;
      end
      exp_q.push_back(8'(base + i));
      tag_q.push_back(tag);
      @(posedge clk_i); #2;
    end
    app_valid_i = 1'b0;
    app_last_i  = 1'b0;
  endtask

  task automatic expect_none(string tag, int hold);
    int v0;
    cur_tag = tag;
    v0 = vcount;
    rx_pulse(hold);
    step(40);
    chk(vcount == v0, tag, vcount - v0, 0);
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int v0;
    step(3);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    chk(tx_valid_o == 1'b0, "R1 valid", int'(tx_valid_o), 0);
    chk(app_ready_o == 1'b1, "R1 ready", int'(app_ready_o), 1);

    // R2 / R5 software request
    cfg(1, 0, 1, 1, 0, 0, 0);
    cur_tag = "R2";
    push_jam("R2");
    rx_pulse(40);
    drain("R2");
    chk(last_run == JLEN, "R2 burst length", last_run, JLEN);

    // R5 sideband request
    cfg(1, 0, 1, 0, 1, 0, 0);
    cur_tag = "R5";
    push_jam("R5");
    rx_pulse(5);
    drain("R5");

    // R3 enable clear
    cfg(0, 1, 1, 1, 1, 100, 10);
    expect_none("R3", 10);
    // R4 full duplex
    cfg(1, 1, 0, 1, 1, 100, 10);
    expect_none("R4", 10);

    // R6 threshold
    cfg(1, 1, 1, 0, 0, 50, 50);
    expect_none("R6 equal", 10);
    cfg(1, 0, 1, 0, 0, 51, 50);
    expect_none("R6 hwfc off", 10);
    cfg(1, 1, 1, 0, 0, 51, 50);
    cur_tag = "R6";
    push_jam("R6");
    rx_pulse(10);
    drain("R6");

    // R7 one jam per rising edge
    cfg(1, 0, 1, 1, 0, 0, 0);
    cur_tag = "R7";
    v0 = vcount;
    push_jam("R7");
    rx_pulse(120);
    drain("R7");
    chk(vcount - v0 == JLEN, "R7 single jam", vcount - v0, JLEN);
    push_jam("R7");
    rx_pulse(8);
    drain("R7 fresh edge");

    // R8 no preemption, no deferral
    cur_tag = "R8";
    step(1);
    fork
      send_frame(12, 8'h10, "R8");
      begin step(4); rx_active_i = 1'b1; step(30); rx_active_i = 1'b0; end
    join
    drain("R8");

    // R10 / R11 coincident trigger and app byte
    cur_tag = "R10";
    push_jam("R10");
    rx_active_i = 1'b1;
    fork
      send_frame(6, 8'hA0, "R10");
      begin
        @(negedge clk_i);
        chk(app_ready_o == 1'b0, "R10 ready", int'(app_ready_o), 0);
        repeat (10) @(negedge clk_i);
        chk(app_ready_o == 1'b0, "R11 ready in jam", int'(app_ready_o), 0);
      end
    join
    rx_active_i = 1'b0;
    drain("R10");

    // R9 frames flow while backpressure is requested
    cur_tag = "R9";
    send_frame(5, 8'h30, "R9");
    step(2);
    send_frame(3, 8'h40, "R9");
    drain("R9");

    step(5);
    chk(exp_q.size() == 0, "end queue", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule